// File: doc/BRIEF.md
# Card Host Event Status and Interrupt Register

This block gathers the event and error flags of a memory-card host controller into one 32-bit status word. It also holds a separate enable word that folds the relevant flags into a single registered interrupt request and a registered wakeup request. The command, data, buffer, SDIO and card-detect engines raise one-cycle set pulses. The pulses arrive on `set_i`, each aligned to the position of its status bit. Live conditions such as buffer fill state, buffer readiness and clock running arrive as levels on `lvl_i`, also aligned by position. Software clears a sticky flag by writing a one to its position.

A single register port serves both words. When `reg_addr_i` is 0 it selects the status word and when it is 1 it selects the enable word. Reads are combinational. A write takes effect at the clock edge on which `reg_we_i` is high. A combinational error summary output tells the data path that the current transfer has failed.

Top module: `sdhost_evt_irq`

## Requirements
- R1: The status bits 0, 1, 2, 3, 5, 11, 12, 13, 14, 24, 25, 30 and 31 are sticky. A pulse on the matching bit of `set_i` sets the bit at the next clock edge, and the bit stays set until it is cleared.
- R2: A status write (`reg_we_i`=1, `reg_addr_i`=0) clears every sticky bit whose `reg_wdata_i` bit is one and leaves the other bits unchanged. If a set pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R3: Status bits 29 and 28 (Y and X buffer empty), 27 and 26 (Y and X buffer full), 8 (clock running), 7 (buffer read ready) and 6 (buffer write ready) show `lvl_i` at the same positions in the same cycle, and writes do not affect them.
- R4: Status bits [10:9] hold a write-CRC result code. The code is loaded from `wcrc_code_i` when `set_i[2]` pulses, and it returns to 0 when bit 2 is cleared without a simultaneous set. Writes to bits 10 and 9 are ignored. Code 2 means the card returned no CRC status.
- R5: `err_o` is high in any cycle where at least one of the stored error bits 0, 1, 2, 3 or 5 is set (summary mask 0x2F).
- R6: An enable write (`reg_we_i`=1, `reg_addr_i`=1) stores bits [18:12] and [4:0] of `reg_wdata_i`. All other enable bits read as 0.
- R7: At each clock edge, `irq_o` takes the OR of the following pairs, each formed with the values present before the edge. Enable bit 0 pairs with status bit 11, enable 1 with status 12, enable 2 with status 13, enable 3 with status 6 and enable 4 with status 7. Enable 12 pairs with `dat0_i`, enable 13 with status 14, enable 14 with status 30 and enable 15 with status 31.
- R8: At each clock edge, `wake_o` takes the OR of three pairs, formed the same way as in R7. Enable bit 16 pairs with status bit 30, enable 17 with status 31 and enable 18 with status 14.
- R9: While `rst_ni` is low, every stored bit, `irq_o` and `wake_o` are 0. After reset the status word shows only the level bits.
- R10: Bits of `set_i` at positions that are not sticky have no effect, and bits of `lvl_i` at positions that are not level bits have no effect. Status bits 4 and [23:15] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 32 | Event set pulses, aligned to status bit positions |
| wcrc_code_i | input | 2 | Write-CRC result code, captured with `set_i[2]` |
| lvl_i | input | 32 | Live level conditions, aligned to status bit positions |
| dat0_i | input | 1 | Live DAT0 line level used as an interrupt source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| err_o | output | 1 | Error summary of the stored error flags |
| irq_o | output | 1 | Registered interrupt request |
| wake_o | output | 1 | Registered wakeup request |

## Verification
Sticky flags, the code field and the enable word become visible on `reg_rdata_o` one edge after their pulse or write. Level bits and `err_o` follow their source within the same cycle. `irq_o` and `wake_o` add one more register, so they reflect the state from before the edge that updates them. The bench's reference model computes the next interrupt and wakeup values from its old state and the live inputs first, and only then updates that state. Inputs change 1 ns after the rising edge, and every output is compared at the falling edge, so each result is read in the cycle it is due.

// File: rtl/sdhost_evt_pkg.sv
package sdhost_evt_pkg;
  parameter int unsigned DW = 32;
  parameter int unsigned CODE_W = 2;
  parameter int unsigned CODE_LSB = 9;
  parameter int unsigned WCRC_ERR_BIT = 2;
  parameter logic [DW-1:0] STICKY_MASK = 32'hC300_782F;
  parameter logic [DW-1:0] LEVEL_MASK  = 32'h3C00_01C0;
  parameter logic [DW-1:0] ERR_MASK    = 32'h0000_002F;
  parameter logic [DW-1:0] EN_MASK     = 32'h0007_F01F;
  parameter int unsigned N_IRQ = 9;
  parameter int unsigned N_WAKE = 3;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_ENABLE = 1'b1} reg_sel_e;
endpackage

// File: rtl/sdhost_evt_flags.sv
module sdhost_evt_flags
  import sdhost_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     set_i,
  input  logic [DW-1:0]     clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [DW-1:0]     flags_o
);
  logic [DW-1:0]     sticky_q;
  logic [CODE_W-1:0] code_q;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       sticky_q[i] <= 1'b0;
        else if (set_i[i]) sticky_q[i] <= 1'b1;
        else if (clr_i[i]) sticky_q[i] <= 1'b0;
      end
    end else begin : g_none
      assign sticky_q[i] = 1'b0;
    end
  end

  // code rides along with the write-CRC error flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  code_q <= '0;
    else if (set_i[WCRC_ERR_BIT]) code_q <= code_i;
    else if (clr_i[WCRC_ERR_BIT]) code_q <= '0;
  end

  assign flags_o = sticky_q | (DW'(code_q) << CODE_LSB);
endmodule

// File: rtl/sdhost_evt_irq_gen.sv
module sdhost_evt_irq_gen
  import sdhost_evt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] view_i,
  input  logic [DW-1:0] en_i,
  input  logic          dat0_i,
  output logic          irq_o,
  output logic          wake_o
);
  logic [N_IRQ-1:0]  irq_src, irq_en;
  logic [N_WAKE-1:0] wk_src, wk_en;
  logic              irq_q, wake_q;

  assign irq_src = {view_i[31], view_i[30], view_i[14], dat0_i,
                    view_i[7], view_i[6], view_i[13], view_i[12], view_i[11]};
  assign irq_en  = {en_i[15], en_i[14], en_i[13], en_i[12], en_i[4:0]};
  assign wk_src  = {view_i[14], view_i[31], view_i[30]};
  assign wk_en   = en_i[18:16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= |(irq_src & irq_en);
      wake_q <= |(wk_src & wk_en);
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/sdhost_evt_irq.sv
module sdhost_evt_irq
  import sdhost_evt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [31:0]   set_i,
  input  logic [1:0]    wcrc_code_i,
  input  logic [31:0]   lvl_i,
  input  logic          dat0_i,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          err_o,
  output logic          irq_o,
  output logic          wake_o
);
  reg_sel_e      sel;
  logic [DW-1:0] clr, flags, view, en_q;

  assign sel = reg_sel_e'(reg_addr_i);
  assign clr = (reg_we_i && sel == SEL_STATUS) ? reg_wdata_i : '0;

  sdhost_evt_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_i & STICKY_MASK),
    .clr_i   (clr),
    .code_i  (wcrc_code_i),
    .flags_o (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            en_q <= '0;
    else if (reg_we_i && sel == SEL_ENABLE) en_q <= reg_wdata_i & EN_MASK;
  end

  assign view = flags | (lvl_i & LEVEL_MASK);

  sdhost_evt_irq_gen u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .view_i (view),
    .en_i   (en_q),
    .dat0_i (dat0_i),
    .irq_o  (irq_o),
    .wake_o (wake_o)
  );

  assign reg_rdata_o = (sel == SEL_ENABLE) ? en_q : view;
  assign err_o       = |(flags & ERR_MASK);
endmodule

// File: rtl/sdhost_evt_irq_chk.sv
module sdhost_evt_irq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] set_i,
  input logic [31:0] lvl_i,
  input logic        reg_we_i,
  input logic        reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        irq_o,
  input logic        wake_o,
  input logic [31:0] flags,
  input logic [31:0] en_q
);
  // R1
  a_r1_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[13] |=> flags[13]);
  // R2
  a_r2_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i && reg_wdata_i[0] && !set_i[0]) |=> !flags[0]);
  a_r2_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i && reg_wdata_i[31] && set_i[31]) |=> flags[31]);
  // R3
  a_r3_level_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_addr_i |-> (reg_rdata_o[7] == lvl_i[7]));
  // R6
  a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q & 32'hFFF8_0FE0) == 32'h0);
  // R7
  a_r7_cmd_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags[13] && en_q[2]) |=> irq_o);
  a_r7_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == 32'h0) |=> !irq_o);
  // R8
  a_r8_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[18:16] == 3'b000) |=> !wake_o);
endmodule

bind sdhost_evt_irq sdhost_evt_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .set_i       (set_i),
  .lvl_i       (lvl_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .wake_o      (wake_o),
  .flags       (flags),
  .en_q        (en_q)
);

// File: tb/sdhost_evt_irq_test.sv
module sdhost_evt_irq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] set_i = '0, lvl_i = '0, reg_wdata_i = '0;
  logic [1:0]  wcrc_code_i = '0;
  logic        dat0_i = 1'b0, reg_we_i = 1'b0, reg_addr_i = 1'b0;
  logic [31:0] reg_rdata_o;
  logic        err_o, irq_o, wake_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [31:0] STK = 32'hC300_782F;
  localparam logic [31:0] LVL = 32'h3C00_01C0;
  localparam logic [31:0] ENM = 32'h0007_F01F;

  sdhost_evt_irq uut (.clk_i(clk), .rst_ni(rst_ni), .set_i(set_i), .wcrc_code_i(wcrc_code_i),
    .lvl_i(lvl_i), .dat0_i(dat0_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .err_o(err_o), .irq_o(irq_o),
    .wake_o(wake_o));

  always #5 clk = ~clk;

  // reference model state
  logic [31:0] m_st, m_en;
  logic [1:0]  m_code;
  logic        m_irq, m_wake;

  function automatic logic bitset(input logic [31:0] v, input int b);
    return v[b];
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_en = 0; m_code = 0; m_irq = 0; m_wake = 0;
    end else begin
      logic [31:0] v, clr;
      v = m_st | ({30'd0, m_code} << 9) | (lvl_i & LVL);
      m_irq = (v[11] & m_en[0]) | (v[12] & m_en[1]) | (v[13] & m_en[2]) |
              (v[6] & m_en[3]) | (v[7] & m_en[4]) | (dat0_i & m_en[12]) |
              (v[14] & m_en[13]) | (v[30] & m_en[14]) | (v[31] & m_en[15]);
      m_wake = (v[30] & m_en[16]) | (v[31] & m_en[17]) | (v[14] & m_en[18]);
      clr = (reg_we_i && !reg_addr_i) ? reg_wdata_i : 32'h0;
      if (set_i[2]) m_code = wcrc_code_i;
      else if (clr[2]) m_code = 2'd0;
      for (int b = 0; b < 32; b++)
        if (STK[b]) begin
          if (bitset(set_i, b)) m_st[b] = 1'b1;
          else if (clr[b]) m_st[b] = 1'b0;
        end
      if (reg_we_i && reg_addr_i) m_en = reg_wdata_i & ENM;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) begin
    logic [31:0] ev;
    ev = m_st | ({30'd0, m_code} << 9) | (lvl_i & LVL);
    if (!reg_addr_i) begin
      chk((reg_rdata_o & STK) == (ev & STK), "R1/R2 sticky", reg_rdata_o & STK, ev & STK);
      chk((reg_rdata_o & LVL) == (ev & LVL), "R3 level", reg_rdata_o & LVL, ev & LVL);
      chk(reg_rdata_o[10:9] == m_code, "R4 code", 32'(reg_rdata_o[10:9]), 32'(m_code));
      chk((reg_rdata_o & 32'h00FF_8010) == 0, "R10 unused", reg_rdata_o & 32'h00FF_8010, 0);
    end else
      chk(reg_rdata_o == m_en, "R6 enable", reg_rdata_o, m_en);
    chk(err_o == |(m_st & 32'h2F), "R5 err", 32'(err_o), 32'(|(m_st & 32'h2F)));
    chk(irq_o == m_irq, "R7 irq", 32'(irq_o), 32'(m_irq));
    chk(wake_o == m_wake, "R8 wake", 32'(wake_o), 32'(m_wake));
  end

  task automatic step(input logic [31:0] s, input logic [31:0] l, input logic we,
                      input logic a, input logic [31:0] wd, input logic [1:0] cd, input logic d0);
    set_i = s; lvl_i = l; reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    wcrc_code_i = cd; dat0_i = d0;
    @(posedge clk); #1;
  endtask

  initial begin
    #12;
    // R9 reset state, checked while held in reset and just after release
    chk(reg_rdata_o == 0 && !irq_o && !wake_o, "R9 reset", reg_rdata_o, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    #3 chk(reg_rdata_o == 0 && !err_o, "R9 after release", reg_rdata_o, 0);
    @(posedge clk); #1;
    step(0, 0, 1, 1, 32'hFFFF_FFFF, 0, 0);               // R6 reserved bits drop
    step(32'h0000_2000, 0, 0, 0, 0, 0, 0);                // R1 end of command, R7 irq
    step(0, 0, 0, 0, 0, 0, 0);
    step(32'h0000_2000, 0, 1, 0, 32'h0000_2000, 0, 0);    // R2 set wins
    step(0, 0, 1, 0, 32'h0000_2000, 0, 0);                // R2 clear
    step(32'h0000_0004, 0, 0, 0, 0, 2'd2, 0);             // R4 no CRC status code, R5
    step(0, LVL, 1, 0, 32'hFFFF_FFFF, 0, 0);              // R3 levels ignore writes, R4 clear
    step(32'h8000_0000, 0, 1, 1, 32'h0002_0000, 0, 0);    // R8 wake on insertion
    step(0, 0, 0, 0, 0, 0, 1);
    step(32'h3CFF_81D0, 32'hC3FF_FE3F, 0, 0, 0, 0, 0);    // R10 wrong-kind positions
    step(0, 0, 1, 0, 32'hFFFF_FFFF, 0, 0);
    for (int i = 0; i < 3000; i++)
      step($urandom & $urandom & $urandom, $urandom, ($urandom % 4) == 0, $urandom % 2,
           $urandom, 2'($urandom), 1'($urandom));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule